// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block is a two-way bus register. It has one path from side A to side B and one path from side B to side A. Each path carries an 18-bit word and has its own four controls: an active-low drive enable, a pass-through select, a data strobe and an active-low strobe gate. Each path runs in one of three ways. In pass-through mode the word goes straight across. In strobed mode the word is captured when the strobe rises while the gate is open. Otherwise the path holds the last stored word. One storage register per path serves both as the transparent latch and as the edge-triggered register.

All controls are sampled by a free-running system clock. A rising edge of a data strobe is seen when the strobe reads low in one system cycle and high in the next. Each path gives out a data word and a drive flag. A pad wrapper uses these to build the tri-state buffers. While pass-through is selected, the storage register reloads on every system clock. So when pass-through ends, the path keeps the word that was last passed across.

Top module: `xcvr_duplex`

## Requirements
- R1: While a path's active-low output enable is high, or reset is asserted, that path's drive flag is 0 and its data output is all zeros. Otherwise the drive flag is 1.
- R2: While a path's pass-through select is high and its output is enabled, its data output equals its data input in the same cycle.
- R3: A strobe rising edge is detected on a system clock edge where the strobe is sampled high and was sampled low at the previous system clock edge. When that happens with pass-through low and the active-low gate low, the input sampled at that edge is stored. From the next cycle on, while pass-through stays low, the output shows the stored word.
- R4: While the active-low gate is high and pass-through is low, strobe edges are ignored and the output keeps its previous value.
- R5: While pass-through is low and the strobe stays steady, whether high or low, the output keeps its previous value.
- R6: In the first cycle after pass-through falls, the output equals the input sampled at the last system clock edge on which pass-through was still high.
- R7: Reset is synchronous and active high. It clears both storage registers to zero. It also marks each strobe as previously high, so a strobe that is already high after reset gives no capture.
- R8: The two paths are independent. The controls and data of one path never change the output of the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| a_din | input | 18 | Word arriving on side A |
| b_din | input | 18 | Word arriving on side B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_pass | input | 1 | A-to-B pass-through select |
| ab_strobe | input | 1 | A-to-B data strobe |
| ab_gate_n | input | 1 | A-to-B strobe gate, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A pass-through select |
| ba_strobe | input | 1 | B-to-A data strobe |
| ba_gate_n | input | 1 | B-to-A strobe gate, active low |
| b_dout | output | 18 | Word to drive onto side B |
| b_drive | output | 1 | Drive flag for the side B pads |
| a_dout | output | 18 | Word to drive onto side A |
| a_drive | output | 1 | Drive flag for the side A pads |

## Verification
The drive flags and the pass-through data are combinational. They are due in the same cycle as their inputs. A strobe capture appears one system clock after the edge on which the strobe is sampled high. A word kept after pass-through falls is the one sampled at the last edge on which pass-through was high. The bench changes inputs only on the falling clock edge. It advances its reference model at each rising edge with the inputs that were held across that edge. It compares both paths at the next falling edge, before new inputs are applied, so every registered result is checked exactly one edge after the edge that caused it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int NUM_DIRS = 2;

    // Per-path control bundle as seen by a lane.
    typedef struct packed {
        logic oe_n;
        logic pass;
        logic strobe;
        logic gate_n;
    } lane_ctl_t;

    // What the storage register does on this system clock.
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_FOLLOW  = 2'd1,
        ST_CAPTURE = 2'd2
    } store_op_t;

    function automatic store_op_t pick_op(input logic pass,
                                          input logic rise,
                                          input logic gate_n);
        store_op_t op;
        if (pass)
            op = ST_FOLLOW;
        else if (rise && !gate_n)
            op = ST_CAPTURE;
        else
            op = ST_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/xcvr_edge_detect.sv
module xcvr_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic seen_q;

    // History resets high so that a strobe already high gives no edge (R7).
    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= 1'b1;
        else
            seen_q <= level;
    end

    assign rise = level & ~seen_q;

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  store_op_t    op,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else begin
            unique case (op)
                ST_FOLLOW,
                ST_CAPTURE: q_r <= din;
                default:    q_r <= q_r;
            endcase
        end
    end

    assign q = q_r;

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);
    logic         rise;
    store_op_t    op;
    logic [W-1:0] held;
    logic [W-1:0] shown;

    xcvr_edge_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (ctl.strobe),
        .rise  (rise)
    );

    assign op = pick_op(ctl.pass, rise, ctl.gate_n);

    xcvr_store #(.W(W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .din  (din),
        .q    (held)
    );

    assign shown = ctl.pass ? din : held;
    assign drive = ~ctl.oe_n & ~rst;
    assign dout  = drive ? shown : '0;

endmodule

// File: rtl/xcvr_duplex.sv
module xcvr_duplex
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_din,
    input  logic [W-1:0] b_din,
    input  logic         ab_oe_n,
    input  logic         ab_pass,
    input  logic         ab_strobe,
    input  logic         ab_gate_n,
    input  logic         ba_oe_n,
    input  logic         ba_pass,
    input  logic         ba_strobe,
    input  logic         ba_gate_n,
    output logic [W-1:0] b_dout,
    output logic         b_drive,
    output logic [W-1:0] a_dout,
    output logic         a_drive
);
    // Index 0 carries A to B, index 1 carries B to A.
    lane_ctl_t          ctl_v   [NUM_DIRS];
    logic [W-1:0]       din_v   [NUM_DIRS];
    logic [W-1:0]       dout_v  [NUM_DIRS];
    logic               drive_v [NUM_DIRS];

    assign ctl_v[0] = '{oe_n: ab_oe_n, pass: ab_pass, strobe: ab_strobe, gate_n: ab_gate_n};
    assign ctl_v[1] = '{oe_n: ba_oe_n, pass: ba_pass, strobe: ba_strobe, gate_n: ba_gate_n};
    assign din_v[0] = a_din;
    assign din_v[1] = b_din;

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_lane
        xcvr_lane #(.W(W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl_v[d]),
            .din   (din_v[d]),
            .dout  (dout_v[d]),
            .drive (drive_v[d])
        );
    end

    assign b_dout  = dout_v[0];
    assign b_drive = drive_v[0];
    assign a_dout  = dout_v[1];
    assign a_drive = drive_v[1];

endmodule

// File: rtl/xcvr_duplex_chk.sv
module xcvr_duplex_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_din,
    input logic [W-1:0] b_din,
    input logic         ab_oe_n,
    input logic         ab_pass,
    input logic         ab_strobe,
    input logic         ab_gate_n,
    input logic         ba_oe_n,
    input logic         ba_pass,
    input logic         ba_strobe,
    input logic         ba_gate_n,
    input logic [W-1:0] b_dout,
    input logic         b_drive,
    input logic [W-1:0] a_dout,
    input logic         a_drive
);
    // High once at least one cycle out of reset has been sampled.
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_ab_off_R1: assert property (@(posedge clk) disable iff (rst)
        ab_oe_n |-> (!b_drive && b_dout == '0));
    assert_ba_off_R1: assert property (@(posedge clk) disable iff (rst)
        ba_oe_n |-> (!a_drive && a_dout == '0));
    assert_ab_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (ab_pass && !ab_oe_n) |-> (b_dout == a_din));
    assert_ba_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (ba_pass && !ba_oe_n) |-> (a_dout == b_din));
    assert_ab_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !ab_pass && !ab_gate_n && ab_strobe && !$past(ab_strobe))
        |=> (ab_pass || ab_oe_n || b_dout == $past(a_din)));
    assert_ab_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !ab_pass && ab_gate_n && !ab_oe_n)
        |=> (ab_pass || ab_oe_n || $stable(b_dout)));
    assert_ab_steady_R5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !ab_pass && !ab_oe_n && ab_strobe == $past(ab_strobe))
        |=> (ab_pass || ab_oe_n || $stable(b_dout)));
    assert_ab_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(ab_pass) && !ab_oe_n) |-> (b_dout == $past(a_din)));

endmodule

bind xcvr_duplex xcvr_duplex_chk #(.W(W)) u_chk (.*);

// File: tb/sim_xcvr_duplex.sv
module sim_xcvr_duplex;
    localparam int W = 18;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic ab_oe_n = 1'b1, ab_pass = 1'b0, ab_strobe = 1'b0, ab_gate_n = 1'b1;
    logic ba_oe_n = 1'b1, ba_pass = 1'b0, ba_strobe = 1'b0, ba_gate_n = 1'b1;
    logic [W-1:0] b_dout, a_dout;
    logic b_drive, a_drive;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_duplex #(.W(W)) u0 (.*);

    // Reference model state, index 0 = A to B, 1 = B to A.
    logic [W-1:0] m_store [2];
    logic         m_prev  [2];
    logic         m_pass_q[2];
    string        m_tag   [2];

    function automatic logic [W-1:0] exp_data(input logic r, input logic oe_n,
                                              input logic pass, input logic [W-1:0] din,
                                              input logic [W-1:0] st);
        if (r || oe_n) return '0;
        return pass ? din : st;
    endfunction

    task automatic model_update();
        logic [W-1:0] din [2];
        logic pass[2], stb[2], gn[2];
        din[0] = a_din;  din[1] = b_din;
        pass[0] = ab_pass; pass[1] = ba_pass;
        stb[0] = ab_strobe; stb[1] = ba_strobe;
        gn[0] = ab_gate_n; gn[1] = ba_gate_n;
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                m_store[d] = '0; m_prev[d] = 1'b1; m_tag[d] = "R7";
            end else begin
                if (pass[d]) m_tag[d] = "R2";
                else if (m_pass_q[d]) m_tag[d] = "R6";
                else if (stb[d] && !m_prev[d] && !gn[d]) m_tag[d] = "R3";
                else if (gn[d]) m_tag[d] = "R4";
                else m_tag[d] = "R5";
                if (pass[d] || (stb[d] && !m_prev[d] && !gn[d])) m_store[d] = din[d];
                m_prev[d] = stb[d];
            end
            m_pass_q[d] = rst ? 1'b0 : pass[d];
        end
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    // Compare at the falling edge, before new inputs are applied.
    task automatic check_all(input string force_tag);
        string t0, t1;
        t0 = (force_tag != "") ? force_tag : (ab_oe_n ? "R1" : m_tag[0]);
        t1 = (force_tag != "") ? force_tag : (ba_oe_n ? "R1" : m_tag[1]);
        // After model_update the tag of a pass-through cycle reflects the held input;
        // the output that is due now uses current inputs and the updated store.
        check(t0, b_dout, exp_data(rst, ab_oe_n, ab_pass, a_din, m_store[0]));
        check(ab_oe_n ? "R1" : t0, {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, !ab_oe_n && !rst});
        check(t1, a_dout, exp_data(rst, ba_oe_n, ba_pass, b_din, m_store[1]));
        check(ba_oe_n ? "R1" : t1, {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, !ba_oe_n && !rst});
    endtask

    task automatic cycle(input string force_tag = "");
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_all(force_tag);
    endtask

    task automatic rand_inputs();
        a_din = W'($urandom); b_din = W'($urandom);
        ab_pass = ($urandom % 4) == 0;  ba_pass = ($urandom % 4) == 0;
        ab_strobe = $urandom % 2;       ba_strobe = $urandom % 2;
        ab_gate_n = $urandom % 2;       ba_gate_n = $urandom % 2;
        ab_oe_n = ($urandom % 7) == 0;  ba_oe_n = ($urandom % 7) == 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int d = 0; d < 2; d++) begin
            m_store[d] = '0; m_prev[d] = 1'b1; m_pass_q[d] = 1'b0; m_tag[d] = "R7";
        end
        // R7: reset state with outputs requested on and strobes high.
        ab_oe_n = 0; ba_oe_n = 0; ab_strobe = 1; ba_strobe = 1; ab_gate_n = 0; ba_gate_n = 0;
        a_din = 18'h2AAAA; b_din = 18'h15555;
        repeat (3) cycle("R7");
        rst = 0;
        // R7: strobe already high after reset gives no capture.
        cycle("R7");
        cycle("R7");

        // R3: capture on both paths, then hold with steady strobe (R5).
        ab_strobe = 0; ba_strobe = 0; cycle();
        a_din = 18'h0F0F0; b_din = 18'h30303; ab_strobe = 1; ba_strobe = 1; cycle("R3");
        a_din = 18'h11111; b_din = 18'h22222; cycle("R5");
        // R4: gate closed, edge ignored.
        ab_gate_n = 1; ba_gate_n = 1; ab_strobe = 0; ba_strobe = 0; cycle("R4");
        ab_strobe = 1; ba_strobe = 1; a_din = 18'h3FFFF; b_din = 18'h00001; cycle("R4");
        cycle("R4");
        // R2 then R6: pass-through, then fall with strobe high.
        ab_pass = 1; ba_pass = 1; a_din = 18'h12345; b_din = 18'h0ABCD; cycle("R2");
        a_din = 18'h1BEEF; b_din = 18'h0CAFE; cycle("R2");
        ab_pass = 0; ba_pass = 0; a_din = 18'h00000; b_din = 18'h3FFFF; cycle("R6");
        // R1: disable while data changes.
        ab_oe_n = 1; ba_oe_n = 1; ab_pass = 1; cycle("R1");
        ab_oe_n = 0; ba_oe_n = 0; ab_pass = 0; cycle("R1");
        // R8: only the A-to-B controls move; B-to-A output must not change.
        ab_gate_n = 0; ab_strobe = 0; cycle("R8");
        ab_strobe = 1; a_din = 18'h2D2D2; ab_pass = 0; cycle("R8");
        ab_pass = 1; ab_oe_n = 1; cycle("R8");

        for (int i = 0; i < 4000; i++) begin
            rand_inputs();
            cycle();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule